// File: doc/BRIEF.md
# Programmable LVDS Lane Bit Mapper

The block turns one parallel video pixel per clock into five 7-bit lane words for an LVDS serializer. The pixel is 24-bit RGB together with horizontal sync, vertical sync, data enable and a control-enable bit. Every one of the 35 output bit positions is a separate 32-way selector. It picks one of these sources: a colour bit, a control signal, a per-pixel toggle, constant one or constant zero. A 5-bit code per position comes from a configuration table, so the lane layout is fully programmable.

The table comes out of reset holding the VESA 24-bit ordering. A single strobe reloads it with the JEIDA ordering or the VESA ordering. Individual lanes can be rewritten through a word-wide write port to build a custom map. Sync and enable polarities can be flipped for panels with active-low signals, and a static software bit can be routed to any position. The lane words come out registered, one cycle after the pixel. Serialization to the bit rate and distribution across links are done downstream.

Top module: `lvds_lane_mapper`

## Requirements
- R1: Selector codes 0 to 7 pick R0..R7, codes 8 to 15 pick G0..G7, and codes 16 to 23 pick B0..B7. In `pix_rgb_i`, R occupies [7:0], G occupies [15:8] and B occupies [23:16].
- R2: Selector codes 24 to 31 pick, in this order: corrected HS, corrected VS, corrected DE, CE, the software bit CI, the toggle, constant 1 and constant 0.
- R3: Reset has the following effects. The table holds the VESA map, `lane_o` is all zero, `lane_valid_o` is 0 and the toggle is 0.
- R4: The VESA preset lists positions 0..6 for each lane. Lane 0 is 1,1,0,0,0,1,1. Lane 1 is R0..R5,G0. Lane 2 is G1..G5,B0,B1. Lane 3 is B2..B5,HS,VS,DE. Lane 4 is R6,R7,G6,G7,B6,B7,CE.
- R5: A preset load with `preset_sel_i` = 2'b01 loads the JEIDA map. Lane 0 is as in R4. Lane 1 is R2..R7,G2. Lane 2 is G3..G7,B2,B3. Lane 3 is B4..B7,HS,VS,DE. Lane 4 is R0,R1,G0,G1,B0,B1,CE. Any other `preset_sel_i` value loads the VESA map.
- R6: A table write uses `cfg_addr_i` = {lane[2:0], half}. Half 0 writes positions 0..3 from `cfg_wdata_i` fields [4:0], [9:5], [14:10] and [19:15]. Half 1 writes positions 4..6 from fields [4:0], [9:5] and [14:10]. Writes to lanes 5..7 are ignored. Lane L position P drives `lane_o[7*L+P]`.
- R7: `hs_inv_i`, `vs_inv_i` and `de_inv_i` invert HS, VS and DE before selection. `ci_i` is the value of source code 28.
- R8: The toggle starts at 0 and inverts after every valid pixel. Each pixel sees the toggle value held before its own inversion.
- R9: `lane_o` and `lane_valid_o` follow a valid pixel by exactly one clock. Cycles with `pix_valid_i` low leave `lane_o` unchanged.
- R10: A table write or preset load affects pixels from the next cycle only. A pixel in the same cycle uses the old table. A preset load takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | 4 | {lane, half} write address |
| cfg_wdata_i | input | 20 | Packed 5-bit selector fields |
| preset_load_i | input | 1 | Reload the whole table from a preset |
| preset_sel_i | input | 2 | 2'b01 JEIDA, others VESA |
| hs_inv_i | input | 1 | Invert HS |
| vs_inv_i | input | 1 | Invert VS |
| de_inv_i | input | 1 | Invert DE |
| ci_i | input | 1 | Software control bit |
| pix_valid_i | input | 1 | Pixel present this cycle |
| pix_rgb_i | input | 24 | {B, G, R} colour |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| ce_i | input | 1 | Control enable |
| lane_valid_o | output | 1 | Lane words valid |
| lane_o | output | 35 | Five 7-bit lane words, lane L at [7L+6:7L] |

## Verification
The bench compares every pixel against both hardwired orderings. A single transposed code in either preset would show up as a wrong bit in lanes 1 to 4. It loads random custom maps through both write halves, and a swapped field or a half that is off by one would land bits in the wrong positions. It also writes to the unused lanes 5 to 7, so a decoder that aliased them onto lanes 0 to 2 would corrupt the map. Other directed cases cover these failures:
- a write in the same cycle as a pixel, where a bypassing table would show the new map one cycle early
- preset and write together, where a wrong priority would keep the written field
- idle cycles, where a mapper that did not hold its output would drift
- a toggle routed to a lane, which shows a toggle that advanced on idle cycles or used its post-inversion value

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;
  localparam int unsigned CODE_W  = 5;
  localparam int unsigned SRC_W   = 1 << CODE_W;
  localparam int unsigned COLOR_W = 8;

  localparam int unsigned R_BASE = 0;
  localparam int unsigned G_BASE = 8;
  localparam int unsigned B_BASE = 16;
  localparam int unsigned C_HS   = 24;
  localparam int unsigned C_VS   = 25;
  localparam int unsigned C_DE   = 26;
  localparam int unsigned C_CE   = 27;
  localparam int unsigned C_CI   = 28;
  localparam int unsigned C_TOG  = 29;
  localparam int unsigned C_ONE  = 30;
  localparam int unsigned C_ZERO = 31;

  typedef enum logic [1:0] {
    PRESET_VESA  = 2'b00,
    PRESET_JEIDA = 2'b01
  } preset_e;

  // Preset selector for one lane position; jeida shifts colour LSBs onto the high lanes
  function automatic logic [CODE_W-1:0] preset_code(input logic jeida, input int lane, input int pos);
    int s;
    int c;
    s = jeida ? 2 : 0;
    case (lane)
      0: c = (pos >= 2 && pos <= 4) ? C_ZERO : C_ONE;
      1: c = (pos < 6) ? R_BASE + pos + s : G_BASE + s;
      2: c = (pos < 5) ? G_BASE + pos + 1 + s : B_BASE + s + pos - 5;
      3: c = (pos < 4) ? B_BASE + pos + 2 + s : C_HS + pos - 4;
      default: c = (pos == 6) ? C_CE : (pos / 2) * 8 + (pos % 2) + (jeida ? 0 : 6);
    endcase
    return CODE_W'(c);
  endfunction
endpackage

// File: rtl/lvds_map_table.sv
module lvds_map_table
  import lvds_map_pkg::*;
#(
  parameter int unsigned N_LANES   = 5,
  parameter int unsigned LANE_BITS = 7,
  parameter int unsigned POS_SPLIT = 4,
  localparam int unsigned LANE_AW  = $clog2(N_LANES),
  localparam int unsigned ADDR_W   = LANE_AW + 1,
  localparam int unsigned WDATA_W  = CODE_W * POS_SPLIT,
  localparam int unsigned NSEL     = N_LANES * LANE_BITS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [ADDR_W-1:0]      cfg_addr_i,
  input  logic [WDATA_W-1:0]     cfg_wdata_i,
  input  logic                   preset_load_i,
  input  logic [1:0]             preset_sel_i,
  output logic [NSEL*CODE_W-1:0] sel_o
);
  logic [CODE_W-1:0] tab_q [N_LANES][LANE_BITS];
  logic [LANE_AW-1:0] wr_lane;
  logic               wr_half;
  logic               wr_ok;
  logic               jeida;

  assign wr_lane = cfg_addr_i[ADDR_W-1:1];
  assign wr_half = cfg_addr_i[0];
  assign wr_ok   = cfg_we_i && (int'(wr_lane) < N_LANES);
  assign jeida   = (preset_sel_i == PRESET_JEIDA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < N_LANES; l++)
        for (int p = 0; p < LANE_BITS; p++)
          tab_q[l][p] <= preset_code(1'b0, l, p);
    end else if (preset_load_i) begin
      for (int l = 0; l < N_LANES; l++)
        for (int p = 0; p < LANE_BITS; p++)
          tab_q[l][p] <= preset_code(jeida, l, p);
    end else if (wr_ok) begin
      for (int l = 0; l < N_LANES; l++) begin
        if (wr_lane == LANE_AW'(l)) begin
          for (int p = 0; p < LANE_BITS; p++) begin
            if (!wr_half && p < POS_SPLIT)
              tab_q[l][p] <= cfg_wdata_i[CODE_W*p +: CODE_W];
            else if (wr_half && p >= POS_SPLIT)
              tab_q[l][p] <= cfg_wdata_i[CODE_W*(p-POS_SPLIT) +: CODE_W];
          end
        end
      end
    end
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    for (genvar p = 0; p < LANE_BITS; p++) begin : g_pos
      assign sel_o[(l*LANE_BITS+p)*CODE_W +: CODE_W] = tab_q[l][p];
    end
  end

  AST_PRESET_CLOCK_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_load_i |=> (sel_o[2*CODE_W +: CODE_W] == CODE_W'(C_ZERO)
                       && sel_o[0 +: CODE_W] == CODE_W'(C_ONE))); // R4
  AST_BAD_LANE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !preset_load_i && int'(wr_lane) >= N_LANES) |=> $stable(sel_o)); // R6
endmodule

// File: rtl/lvds_pixel_cond.sv
module lvds_pixel_cond
  import lvds_map_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pix_valid_i,
  input  logic [3*COLOR_W-1:0] pix_rgb_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  input  logic                 ce_i,
  input  logic                 hs_inv_i,
  input  logic                 vs_inv_i,
  input  logic                 de_inv_i,
  input  logic                 ci_i,
  output logic [SRC_W-1:0]     src_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tog_q <= 1'b0;
    else if (pix_valid_i) tog_q <= ~tog_q;
  end

  always_comb begin
    src_o = '0;
    src_o[B_BASE-1:R_BASE] = pix_rgb_i[2*COLOR_W-1:0];
    src_o[C_HS-1:B_BASE]   = pix_rgb_i[3*COLOR_W-1:2*COLOR_W];
    src_o[C_HS]   = hsync_i ^ hs_inv_i;
    src_o[C_VS]   = vsync_i ^ vs_inv_i;
    src_o[C_DE]   = de_i ^ de_inv_i;
    src_o[C_CE]   = ce_i;
    src_o[C_CI]   = ci_i;
    src_o[C_TOG]  = tog_q;
    src_o[C_ONE]  = 1'b1;
    src_o[C_ZERO] = 1'b0;
  end

  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> (tog_q != $past(tog_q))); // R8
  AST_TOGGLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> $stable(tog_q)); // R8
endmodule

// File: rtl/lvds_lane_mux.sv
module lvds_lane_mux
  import lvds_map_pkg::*;
#(
  parameter int unsigned NSEL = 35
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [SRC_W-1:0]       src_i,
  input  logic [NSEL*CODE_W-1:0] sel_i,
  output logic [NSEL-1:0]        lane_o,
  output logic                   valid_o
);
  logic [NSEL-1:0] bit_d;

  for (genvar b = 0; b < NSEL; b++) begin : g_bit
    assign bit_d[b] = src_i[sel_i[b*CODE_W +: CODE_W]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) lane_o <= bit_d;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(lane_o) && !valid_o)); // R9
  AST_CONST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i[0 +: CODE_W] == CODE_W'(C_ZERO)) |=> !lane_o[0]); // R2
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_map_pkg::*;
#(
  parameter int unsigned N_LANES   = 5,
  parameter int unsigned LANE_BITS = 7,
  parameter int unsigned POS_SPLIT = 4,
  localparam int unsigned ADDR_W   = $clog2(N_LANES) + 1,
  localparam int unsigned WDATA_W  = CODE_W * POS_SPLIT,
  localparam int unsigned NSEL     = N_LANES * LANE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [WDATA_W-1:0]   cfg_wdata_i,
  input  logic                 preset_load_i,
  input  logic [1:0]           preset_sel_i,
  input  logic                 hs_inv_i,
  input  logic                 vs_inv_i,
  input  logic                 de_inv_i,
  input  logic                 ci_i,
  input  logic                 pix_valid_i,
  input  logic [3*COLOR_W-1:0] pix_rgb_i,
  input  logic                 hsync_i,
  input  logic                 vsync_i,
  input  logic                 de_i,
  input  logic                 ce_i,
  output logic                 lane_valid_o,
  output logic [NSEL-1:0]      lane_o
);
  logic [NSEL*CODE_W-1:0] sel;
  logic [SRC_W-1:0]       src;

  lvds_map_table #(
    .N_LANES(N_LANES), .LANE_BITS(LANE_BITS), .POS_SPLIT(POS_SPLIT)
  ) u_table (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .preset_load_i, .preset_sel_i, .sel_o(sel)
  );

  lvds_pixel_cond u_cond (
    .clk_i, .rst_ni, .pix_valid_i, .pix_rgb_i, .hsync_i, .vsync_i, .de_i, .ce_i,
    .hs_inv_i, .vs_inv_i, .de_inv_i, .ci_i, .src_o(src)
  );

  lvds_lane_mux #(.NSEL(NSEL)) u_mux (
    .clk_i, .rst_ni, .valid_i(pix_valid_i), .src_i(src), .sel_i(sel),
    .lane_o, .valid_o(lane_valid_o)
  );
endmodule

// File: tb/lvds_lane_mapper_test.sv
module lvds_lane_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic        preset_load = 1'b0;
  logic [1:0]  preset_sel = '0;
  logic        hs_inv = 1'b0, vs_inv = 1'b0, de_inv = 1'b0, ci = 1'b0;
  logic        pix_valid = 1'b0;
  logic [23:0] rgb = '0;
  logic        hs = 1'b0, vs = 1'b0, de = 1'b0, ce = 1'b0;
  logic        lane_valid;
  logic [34:0] lanes;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mtab [5][7];
  bit tog = 0;
  int vesa_t  [5][7] = '{'{30,30,31,31,31,30,30}, '{0,1,2,3,4,5,8}, '{9,10,11,12,13,16,17},
                         '{18,19,20,21,24,25,26}, '{6,7,14,15,22,23,27}};
  int jeida_t [5][7] = '{'{30,30,31,31,31,30,30}, '{2,3,4,5,6,7,10}, '{11,12,13,14,15,18,19},
                         '{20,21,22,23,24,25,26}, '{0,1,8,9,16,17,27}};

  always #2.5 clk = ~clk;

  lvds_lane_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .preset_load_i(preset_load), .preset_sel_i(preset_sel),
    .hs_inv_i(hs_inv), .vs_inv_i(vs_inv), .de_inv_i(de_inv), .ci_i(ci),
    .pix_valid_i(pix_valid), .pix_rgb_i(rgb), .hsync_i(hs), .vsync_i(vs), .de_i(de),
    .ce_i(ce), .lane_valid_o(lane_valid), .lane_o(lanes)
  );

  task automatic check(input logic [34:0] got, input logic [34:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [34:0] expect_lanes();
    logic [31:0] s;
    logic [34:0] e;
    s = {1'b0, 1'b1, tog, ci, ce, de ^ de_inv, vs ^ vs_inv, hs ^ hs_inv, rgb};
    for (int l = 0; l < 5; l++)
      for (int p = 0; p < 7; p++)
        e[7*l+p] = s[mtab[l][p]];
    return e;
  endfunction

  // at negedge: drive pixel (optionally with table ops already driven), check one cycle later
  task automatic pixel(input logic [23:0] c, input logic [3:0] ctl, input string req);
    logic [34:0] e;
    rgb = c; {hs, vs, de, ce} = ctl; pix_valid = 1'b1;
    e = expect_lanes();
    @(negedge clk);
    tog = ~tog;
    pix_valid = 1'b0;
    check(lanes, e, req);
    check({34'd0, lane_valid}, 35'd1, req);
  endtask

  task automatic rand_pixel(input string req);
    pixel(24'($urandom), 4'($urandom), req);
  endtask

  task automatic apply_write(input int lane, input int half, input logic [19:0] d);
    if (lane < 5)
      for (int p = 0; p < 7; p++) begin
        if (half == 0 && p < 4) mtab[lane][p] = int'(d[5*p +: 5]);
        if (half == 1 && p >= 4) mtab[lane][p] = int'(d[5*(p-4) +: 5]);
      end
  endtask

  task automatic cfg_write(input int lane, input int half, input logic [19:0] d);
    cfg_we = 1'b1; cfg_addr = {3'(lane), 1'(half)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    apply_write(lane, half, d);
  endtask

  task automatic load_preset(input logic [1:0] sel);
    preset_load = 1'b1; preset_sel = sel;
    @(negedge clk);
    preset_load = 1'b0;
    mtab = (sel == 2'b01) ? jeida_t : vesa_t;
  endtask

  initial begin
    logic [34:0] held;
    void'($urandom(32'h5EED_1234));
    mtab = vesa_t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lanes, '0, "R3 reset lanes");
    check({34'd0, lane_valid}, '0, "R3 reset valid");

    // default VESA after reset, colours and syncs
    pixel(24'hFFFFFF, 4'b0000, "R3 R4 default vesa white");
    pixel(24'h000000, 4'b1111, "R2 R4 syncs high");
    repeat (20) rand_pixel("R1 R4 vesa random");

    // idle holds output, toggle frozen
    held = lanes;
    rgb = ~rgb; hs = ~hs;
    repeat (3) @(negedge clk);
    check(lanes, held, "R9 idle hold");
    check({34'd0, lane_valid}, '0, "R9 idle valid low");

    load_preset(2'b01);
    repeat (20) rand_pixel("R5 jeida random");
    load_preset(2'b11);
    repeat (10) rand_pixel("R5 other sel gives vesa");

    // toggle and CI routed onto lane 1; polarity correction
    cfg_write(1, 0, {5'd29, 5'd28, 5'd29, 5'd28});
    cfg_write(1, 1, {5'd0, 5'd24, 5'd25, 5'd26});
    ci = 1'b1; hs_inv = 1'b1; vs_inv = 1'b1; de_inv = 1'b1;
    repeat (8) rand_pixel("R7 R8 inverted syncs, ci, toggle");
    repeat (2) @(negedge clk);
    rand_pixel("R8 toggle frozen across idle");
    ci = 1'b0; hs_inv = 1'b0;
    repeat (4) rand_pixel("R7 mixed polarity");

    // ignored lanes
    cfg_write(5, 0, 20'hFFFFF);
    cfg_write(6, 1, 20'h00000);
    cfg_write(7, 0, 20'h12345);
    repeat (4) rand_pixel("R6 lanes 5-7 ignored");

    // random custom maps
    for (int k = 0; k < 12; k++) begin
      for (int l = 0; l < 5; l++) begin
        cfg_write(l, 0, 20'($urandom));
        cfg_write(l, 1, 20'($urandom));
      end
      repeat (6) rand_pixel("R1 R2 R6 custom map");
    end

    // write in same cycle as a pixel: old table for that pixel
    cfg_we = 1'b1; cfg_addr = {3'd2, 1'b0}; cfg_wdata = {5'd31, 5'd31, 5'd30, 5'd30};
    pixel(24'h5A5A5A, 4'b1010, "R10 same-cycle write uses old map");
    cfg_we = 1'b0;
    apply_write(2, 0, {5'd31, 5'd31, 5'd30, 5'd30});
    pixel(24'hA5A5A5, 4'b0101, "R10 write visible next pixel");

    // preset beats write in the same cycle
    preset_load = 1'b1; preset_sel = 2'b00;
    cfg_we = 1'b1; cfg_addr = {3'd1, 1'b0}; cfg_wdata = 20'hFFFFF;
    @(negedge clk);
    preset_load = 1'b0; cfg_we = 1'b0;
    mtab = vesa_t;
    repeat (4) rand_pixel("R10 preset priority over write");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule